// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block takes one fast input clock and derives two slower clocks from it. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter, one fifth or one sixth of the input rate. Both outputs are registered on the rising edge of the same input clock and are decoded from one shared period counter, so any rising edge that the two outputs have in common falls on the same input edge.

A common enable is captured on the falling edge of the input clock. It stops or restarts both dividers without producing a shortened high pulse: a high pulse already in progress always runs to full length, and the dividers then hold their phase with both outputs low. An active-low asynchronous master reset clears all divider state. Several instances that leave reset on the same edge, with equal selects and enable, produce identical waveforms. The ratio selects are captured at the first rising edge after reset and are ignored after that.

Top module: `clkdiv_dual`

## Requirements
- R1: With sel_a_i = 0, clk_a_o has a period of 2 input cycles and is high for 1 of them. With sel_a_i = 1, the period is 4 cycles and the output is high for 2.
- R2: With sel_b_i = 2'b00 or 2'b11, clk_b_o has a period of 4 input cycles and is high for 2. With 2'b01, the period is 6 cycles and the output is high for 3. With 2'b10, the period is 5 cycles: high for 3, then low for 2.
- R3: After reset release, both outputs first rise on the same input edge. They then rise together again at the start of every common period, which is the least common multiple of the two ratios.
- R4: en_i is sampled on the falling edge of clk_i. The dividers advance on a rising edge only if the enable sampled at the falling edge just before it was high, or if an output pulse is still high.
- R5: Every high pulse on either output lasts exactly its nominal number of input cycles (R1/R2), including a pulse that is running when the enable drops.
- R6: Once disabled and after any running pulse has finished, both outputs stay low and the divider phase is held. After re-enable, counting resumes from the held phase.
- R7: While rst_ni is low, both outputs are low. Asserting rst_ni clears the outputs at once, without waiting for a clock edge.
- R8: The selects are captured at the first rising edge after reset. Later changes to sel_a_i or sel_b_i have no effect until the next reset.
- R9: Two instances that are reset together and driven with the same selects and enable produce identical outputs on every cycle.
- R10: Each per-output phase counter returns to zero whenever the common period counter wraps. This restores the mutual alignment of the two outputs from any register state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| en_i | input | 1 | Common enable, sampled on the falling clock edge |
| sel_a_i | input | 1 | Ratio select for output A (0: /2, 1: /4) |
| sel_b_i | input | 2 | Ratio select for output B (00: /4, 01: /6, 10: /5, 11: /4) |
| clk_a_o | output | 1 | Divided clock A |
| clk_b_o | output | 1 | Divided clock B |

## Verification
The ratio table is applied for all eight select combinations, including the unused code 11. Each combination runs with the enable held high for three common periods. This separates a wrong ratio, a wrong duty split on the divide-by-5 output and a missing common rising edge. A pseudo-random enable pattern on the 4/5 setting shows whether pulses in progress complete at full length and whether the held phase is resumed exactly. A select change made after start-up shows whether the captured configuration is held. A second instance with a different history shows whether a shared reset aligns two copies.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned CNT_W = 5;  // holds common period up to 20
  localparam int unsigned PH_W  = 3;  // holds ratio up to 6

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [PH_W-1:0]  ph_t;

  function automatic ph_t div_a(input logic s);
    return s ? ph_t'(4) : ph_t'(2);
  endfunction

  function automatic ph_t hi_a(input logic s);
    return s ? ph_t'(2) : ph_t'(1);
  endfunction

  function automatic ph_t div_b(input logic [1:0] s);
    case (s)
      2'b01:   return ph_t'(6);
      2'b10:   return ph_t'(5);
      default: return ph_t'(4);
    endcase
  endfunction

  function automatic ph_t hi_b(input logic [1:0] s);
    case (s)
      2'b01, 2'b10: return ph_t'(3);
      default:      return ph_t'(2);
    endcase
  endfunction

  // least common multiple of both ratios
  function automatic cnt_t period(input logic sa, input logic [1:0] sb);
    case ({sa, sb})
      3'b001:  return cnt_t'(6);
      3'b010:  return cnt_t'(10);
      3'b101:  return cnt_t'(12);
      3'b110:  return cnt_t'(20);
      default: return cnt_t'(4);
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_en_sync.sv
module clkdiv_en_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_q_o
);
  // captured while the input clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_o <= 1'b0;
    else         en_q_o <= en_i;
  end
endmodule

// File: rtl/clkdiv_base.sv
module clkdiv_base #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last   = (cnt_q >= period_i - CNT_W'(1));
  assign wrap_o = adv_i && last;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
  end

  a_r10_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_i);
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
  parameter int unsigned PH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            wrap_i,
  input  logic [PH_W-1:0] div_i,
  input  logic [PH_W-1:0] hi_i,
  output logic            clk_o
);
  logic [PH_W-1:0] ph_q;
  logic            out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      out_q <= 1'b0;
    end else begin
      out_q <= adv_i && (ph_q < hi_i);
      if (adv_i) begin
        // common wrap re-zeroes the phase (R10)
        if (wrap_i || ph_q >= div_i - PH_W'(1)) ph_q <= '0;
        else                                    ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  assign clk_o = out_q;

  // checker: length of the current high run
  logic [PH_W-1:0] hi_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_run <= '0;
    else if (out_q) hi_run <= hi_run + PH_W'(1);
    else            hi_run <= '0;
  end

  a_r5_full_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_q && hi_run != '0) |-> (hi_run == hi_i));

  a_r10_phase_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (ph_q == '0));
endmodule

// File: rtl/clkdiv_dual.sv
module clkdiv_dual
  import clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       clk_a_o,
  output logic       clk_b_o
);
  logic       cfg_vld;
  logic       sel_a_q;
  logic [1:0] sel_b_q;
  logic       sel_a;
  logic [1:0] sel_b;
  logic       en_q;
  logic       adv;
  logic       wrap;
  cnt_t       cnt;

  // selects are frozen from the first edge after reset (R8)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_vld <= 1'b0;
      sel_a_q <= 1'b0;
      sel_b_q <= 2'b00;
    end else if (!cfg_vld) begin
      cfg_vld <= 1'b1;
      sel_a_q <= sel_a_i;
      sel_b_q <= sel_b_i;
    end
  end

  assign sel_a = cfg_vld ? sel_a_q : sel_a_i;
  assign sel_b = cfg_vld ? sel_b_q : sel_b_i;

  clkdiv_en_sync u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .en_q_o (en_q)
  );

  // keep stepping while any pulse is high so none is cut short
  assign adv = en_q || clk_a_o || clk_b_o;

  clkdiv_base #(.CNT_W(CNT_W)) u_base (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .period_i (period(sel_a, sel_b)),
    .wrap_o   (wrap),
    .cnt_o    (cnt)
  );

  clkdiv_phase #(.PH_W(PH_W)) u_ph_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .wrap_i (wrap),
    .div_i  (div_a(sel_a)),
    .hi_i   (hi_a(sel_a)),
    .clk_o  (clk_a_o)
  );

  clkdiv_phase #(.PH_W(PH_W)) u_ph_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .wrap_i (wrap),
    .div_i  (div_b(sel_b)),
    .hi_i   (hi_b(sel_b)),
    .clk_o  (clk_b_o)
  );

  a_r3_common_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && cnt == '0) |=> (clk_a_o && clk_b_o));

  a_r6_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !clk_a_o && !clk_b_o) |=> (!clk_a_o && !clk_b_o && $stable(cnt)));

  a_r4_start_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_a_o && !clk_b_o && !en_q) |=> !$rose(clk_a_o));

  always @(negedge clk_i) begin
    if (!rst_ni) a_r7_reset_low: assert (!clk_a_o && !clk_b_o);
  end
endmodule

// File: tb/clkdiv_dual_bench.sv
`timescale 1ns/1ps
module clkdiv_dual_bench;
  typedef struct packed {
    logic       sa;
    logic [1:0] sb;
    int         na, ha, nb, hb, p;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 2, 1, 4, 2, 4},
    '{1'b0, 2'b01, 2, 1, 6, 3, 6},
    '{1'b0, 2'b10, 2, 1, 5, 3, 10},
    '{1'b0, 2'b11, 2, 1, 4, 2, 4},
    '{1'b1, 2'b00, 4, 2, 4, 2, 4},
    '{1'b1, 2'b01, 4, 2, 6, 3, 12},
    '{1'b1, 2'b10, 4, 2, 5, 3, 20},
    '{1'b1, 2'b11, 4, 2, 4, 2, 4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, en2 = 1'b1;
  logic sel_a = 1'b0, sel_a2 = 1'b1;
  logic [1:0] sel_b = 2'b00, sel_b2 = 2'b10;
  logic a, b, a2, b2;

  int checks = 0, errors = 0;
  int na, ha, nb, hb, p;
  int m_k;
  bit m_enq, ea, eb;
  bit mon_on = 1'b0;
  int run_a = 0, run_b = 0;
  logic [7:0] lfsr = 8'hA5;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkdiv_dual u_clkdiv_dual (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .clk_a_o(a), .clk_b_o(b));

  clkdiv_dual u_twin (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en2), .sel_a_i(sel_a2), .sel_b_i(sel_b2),
    .clk_a_o(a2), .clk_b_o(b2));

  task automatic check(input bit ok, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic load(input vec_t v);
    sel_a = v.sa; sel_b = v.sb;
    na = v.na; ha = v.ha; nb = v.nb; hb = v.hb; p = v.p;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(a === 1'b0 && b === 1'b0, "R7 outputs low in reset", {a, b}, 2'b00);
    rst_n = 1'b1;
    m_k = 0; m_enq = 1'b0; ea = 1'b0; eb = 1'b0;
  endtask

  // one input cycle of the requirement model
  task automatic step(input logic new_en, input string tag);
    bit adv;
    @(negedge clk); #1;
    adv = m_enq || ea || eb;
    if (adv) begin
      ea = (m_k % na) < ha;
      eb = (m_k % nb) < hb;
      if (m_k == 0)
        check(a === 1'b1 && b === 1'b1, "R3 shared rising edge", {a, b}, 2'b11);
      m_k = (m_k + 1) % p;
    end else begin
      ea = 1'b0; eb = 1'b0;
    end
    check(a === ea && b === eb, tag, {a, b}, {ea, eb});
    m_enq = en;
    en = new_en;
  endtask

  // independent pulse-length monitor (R5)
  always @(negedge clk) begin
    if (!rst_n || !mon_on) begin
      run_a = 0; run_b = 0;
    end else begin
      if (a) run_a++;
      else begin
        if (run_a != 0) check(run_a == ha, "R5 pulse length A", 2'(run_a), 2'(ha));
        run_a = 0;
      end
      if (b) run_b++;
      else begin
        if (run_b != 0) check(run_b == hb, "R5 pulse length B", 2'(run_b), 2'(hb));
        run_b = 0;
      end
    end
  end

  // twin gets its own enable history before the alignment test
  always @(posedge clk) if (!done) en2 <= lfsr[3];

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    load(VECS[0]);
    do_reset();

    // ratio table, enable held high (R1 R2)
    mon_on = 1'b1;
    for (int i = 0; i < NV; i++) begin
      load(VECS[i]);
      do_reset();
      for (int c = 0; c < 3 * VECS[i].p + 2; c++) step(1'b1, "R1 R2 ratio/duty");
    end

    // pseudo-random enable on the 4/5 setting (R4 R5 R6)
    load(VECS[6]);
    do_reset();
    for (int c = 0; c < 600; c++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step((lfsr[2:0] != 3'b000) ? en : ~en, "R4 R6 gated sequence");
    end

    // long disable, then resume from held phase (R6)
    for (int c = 0; c < 30; c++) step(1'b0, "R6 disabled hold");
    check(a === 1'b0 && b === 1'b0, "R6 held low", {a, b}, 2'b00);
    for (int c = 0; c < 45; c++) step(1'b1, "R6 resume from held phase");

    // selects ignored after capture (R8)
    load(VECS[0]);
    do_reset();
    for (int c = 0; c < 8; c++) step(1'b1, "R8 before select change");
    sel_a = 1'b1; sel_b = 2'b10;
    for (int c = 0; c < 16; c++) step(1'b1, "R8 select change ignored");
    load(VECS[6]);
    do_reset();
    for (int c = 0; c < 42; c++) step(1'b1, "R8 new select after reset");

    // asynchronous reset mid-cycle (R7)
    mon_on = 1'b0;
    while (!(ea || eb)) step(1'b1, "R7 run before async reset");
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    check(a === 1'b0 && b === 1'b0, "R7 async clear", {a, b}, 2'b00);
    mon_on = 1'b1;

    // two instances aligned by a shared reset (R9)
    done = 1'b1;
    load(VECS[5]);
    sel_a2 = VECS[5].sa; sel_b2 = VECS[5].sb;
    en = 1'b1; en2 = 1'b1;
    do_reset();
    for (int c = 0; c < 40; c++) begin
      step(1'b1, "R9 reference");
      check(a === a2 && b === b2, "R9 twin matches", {a2, b2}, {a, b});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule